// File: doc/BRIEF.md
# Query Response Lane Formatter

This block forms the read word returned when a bank of identical flash devices, wired side by side on one data bus, is in identifier mode or table-query mode. Each device answers the same query on its own byte lanes. The block therefore starts from the bus byte address and the three elaboration-time widths: the bank width, the width each device is strapped to, and the widest width that device could run at. From these it derives the index that each device sees. It takes one byte from the query table, or one of the two identifier codes, and copies that answer onto every device's lanes.

A bus read can be wider than the bank. In that case the block answers as if several bank-wide reads had been made at consecutive bank-width address steps, and it places those answers from the least significant byte upward. Bytes above the requested read size are zero. A request is accepted in one cycle and its result is registered once, so the result is ready on the next cycle.

Top module: `qry_lane_fmt`

## Requirements
- R1: BANK_W, DEV_W and MAX_DEV_W are each a power of two from 1 to 4 bytes, with DEV_W no larger than MAX_DEV_W and no larger than BANK_W.
- R2: rd_valid rises in the cycle after a cycle with rd_en high and is low after a cycle with rd_en low. rd_data keeps its value when no request is made. Reset clears both to zero.
- R3: The device index is the slot byte address shifted right by log2(BANK_W) + log2(MAX_DEV_W) - log2(DEV_W).
- R4: In table mode (id_mode = 0), an index at or above TBL_LEN gives a zero answer for that device.
- R5: The table holds 0x51, 0x52, 0x59 ("QRY") at indices 0x10, 0x11, 0x12. It also holds 0x01 at 0x13, 0x31 at 0x15, 0x45 at 0x1B, 0x55 at 0x1C, 0x01 at 0x2C, and 0x50, 0x52, 0x49 at 0x31 to 0x33. Every other index holds zero.
- R6: In table mode, a device strapped narrower than its maximum answers only when DEV_W = 1, and then the table byte fills its slot. Any other narrower strapping gives zero. A device at its maximum width answers with the byte zero-extended to DEV_W bytes.
- R7: In identifier mode (id_mode = 1), bits 7:0 of the index select the answer: 0 selects MFR_CODE, 1 selects DEV_CODE, and any other value selects zero. Each answer is taken as its low DEV_W bytes, with zeros added above bit 15.
- R8: The answer of one device is copied into every DEV_W-byte slot of the bank word.
- R9: Bank slot k of the 4-byte bus word covers bytes k*BANK_W upward and is answered for byte address rd_addr + k*BANK_W, taken modulo 2^ADDR_W.
- R10: rd_size selects the bytes returned: 0 returns 1 byte, 1 returns 2 bytes, and 2 or 3 return 4 bytes. Bytes above the selected size are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read request this cycle |
| rd_addr | input | ADDR_W | Bus byte address of the read |
| rd_size | input | 2 | Read size code (R10) |
| id_mode | input | 1 | 1 = identifier read, 0 = table query |
| rd_valid | output | 1 | Result valid, one cycle after the request |
| rd_data | output | 32 | Formatted read word |

## Verification
The same stimulus drives three strappings side by side:
- a 4-byte bank of x8 devices that can run at x16, which shows repetition and the 3-bit index shift;
- a 2-byte bank of native x16 devices with a short table, which shows zero-extension, the table limit and two bank slots per bus word;
- a 4-byte bank of x32-capable parts strapped x16, which must give zero in table mode but still return identifier codes.

Identifier reads use indices 0, 1 and 2, plus an index whose upper bits are set, so that masking to the low 8 bits can be seen. Table reads at and next to the table limit separate the limit check from table bytes that are simply zero. Each read size is tried on the same address to show the byte masking.

// File: rtl/qry_lane_pkg.sv
package qry_lane_pkg;

  localparam int unsigned BUS_BYTES = 4;

  typedef enum logic [1:0] {
    ID_NONE = 2'd0,
    ID_MFR  = 2'd1,
    ID_DEV  = 2'd2
  } id_sel_e;

  // log2 of a width restricted to 1, 2 or 4 bytes
  function automatic int unsigned width_log2(int unsigned w);
    return (w >= 4) ? 2 : ((w >= 2) ? 1 : 0);
  endfunction

  // index shift for one strapping
  function automatic int unsigned index_shift(int unsigned bank_w, int unsigned dev_w,
                                              int unsigned max_w);
    return width_log2(bank_w) + width_log2(max_w) - width_log2(dev_w);
  endfunction

  // fixed query table content
  function automatic logic [7:0] qry_table_byte(logic [31:0] idx);
    case (idx)
      32'h10:  return 8'h51;
      32'h11:  return 8'h52;
      32'h12:  return 8'h59;
      32'h13:  return 8'h01;
      32'h15:  return 8'h31;
      32'h1B:  return 8'h45;
      32'h1C:  return 8'h55;
      32'h2C:  return 8'h01;
      32'h31:  return 8'h50;
      32'h32:  return 8'h52;
      32'h33:  return 8'h49;
      default: return 8'h00;
    endcase
  endfunction

  // byte enable mask for a read size code
  function automatic logic [BUS_BYTES*8-1:0] size_mask(logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/qry_index_xlate.sv
module qry_index_xlate
  import qry_lane_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BANK_W    = 4,
  parameter int unsigned DEV_W     = 1,
  parameter int unsigned MAX_DEV_W = 2,
  parameter int unsigned TBL_LEN   = 'h52,
  parameter int unsigned SLOT      = 0
) (
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] tbl_idx,
  output logic              idx_oob,
  output id_sel_e           id_sel
);

  localparam int unsigned      SHIFT = index_shift(BANK_W, DEV_W, MAX_DEV_W);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(SLOT * BANK_W);

  logic [ADDR_W-1:0] slot_addr;
  logic [7:0]        idx_lo;

  assign slot_addr = base_addr + STEP;
  assign tbl_idx   = ADDR_W'(slot_addr >> SHIFT);
  assign idx_oob   = ({32'd0, tbl_idx} >= {{ADDR_W{1'b0}}, 32'(TBL_LEN)});
  assign idx_lo    = 8'(tbl_idx);

  always_comb begin
    case (idx_lo)
      8'd0:    id_sel = ID_MFR;
      8'd1:    id_sel = ID_DEV;
      default: id_sel = ID_NONE;
    endcase
  end

endmodule

// File: rtl/qry_bank_word.sv
module qry_bank_word
  import qry_lane_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BANK_W    = 4,
  parameter int unsigned DEV_W     = 1,
  parameter int unsigned MAX_DEV_W = 2,
  parameter logic [15:0] MFR_CODE  = 16'h1C89,
  parameter logic [15:0] DEV_CODE  = 16'h4A17
) (
  input  logic [ADDR_W-1:0]   tbl_idx,
  input  logic                idx_oob,
  input  id_sel_e             id_sel,
  input  logic                id_mode,
  output logic [BANK_W*8-1:0] bank_word
);

  localparam int unsigned DW8    = DEV_W * 8;
  localparam int unsigned NDEV   = BANK_W / DEV_W;

  logic [7:0]     tbl_byte;
  logic [DW8-1:0] tbl_dev;
  logic [DW8-1:0] ident_dev;
  logic [DW8-1:0] dev_val;

  assign tbl_byte = idx_oob ? 8'h00 : qry_table_byte(32'(tbl_idx));

  generate
    if (DEV_W < MAX_DEV_W) begin : g_narrow
      if (DEV_W == 1) begin : g_x8
        // repeated byte: the x8 slot is the low byte of the repeated pattern
        assign tbl_dev = DW8'(tbl_byte);
      end else begin : g_unsup
        assign tbl_dev = '0;
      end
    end else begin : g_native
      assign tbl_dev = DW8'(tbl_byte);
    end
  endgenerate

  always_comb begin
    case (id_sel)
      ID_MFR:  ident_dev = DW8'({16'h0, MFR_CODE});
      ID_DEV:  ident_dev = DW8'({16'h0, DEV_CODE});
      default: ident_dev = '0;
    endcase
  end

  assign dev_val = id_mode ? ident_dev : tbl_dev;

  for (genvar s = 0; s < NDEV; s++) begin : g_dev_slot
    assign bank_word[s*DW8 +: DW8] = dev_val;
  end

endmodule

// File: rtl/qry_lane_fmt.sv
module qry_lane_fmt
  import qry_lane_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BANK_W    = 4,
  parameter int unsigned DEV_W     = 1,
  parameter int unsigned MAX_DEV_W = 2,
  parameter int unsigned TBL_LEN   = 'h52,
  parameter logic [15:0] MFR_CODE  = 16'h1C89,
  parameter logic [15:0] DEV_CODE  = 16'h4A17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        rd_size,
  input  logic              id_mode,
  output logic              rd_valid,
  output logic [31:0]       rd_data
);

  localparam int unsigned NSLOT = BUS_BYTES / BANK_W;
  localparam int unsigned BW8   = BANK_W * 8;

  logic [BW8-1:0]    slot_word [NSLOT];
  logic [ADDR_W-1:0] slot_idx  [NSLOT];
  logic              slot_oob  [NSLOT];
  id_sel_e           slot_sel  [NSLOT];
  logic [31:0]       assembled;
  logic [31:0]       masked;
  logic              slot0_oob;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    qry_index_xlate #(
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DEV_W(DEV_W),
      .MAX_DEV_W(MAX_DEV_W), .TBL_LEN(TBL_LEN), .SLOT(k)
    ) u_xlate (
      .base_addr(rd_addr),
      .tbl_idx  (slot_idx[k]),
      .idx_oob  (slot_oob[k]),
      .id_sel   (slot_sel[k])
    );

    qry_bank_word #(
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DEV_W(DEV_W),
      .MAX_DEV_W(MAX_DEV_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
    ) u_word (
      .tbl_idx  (slot_idx[k]),
      .idx_oob  (slot_oob[k]),
      .id_sel   (slot_sel[k]),
      .id_mode  (id_mode),
      .bank_word(slot_word[k])
    );

    assign assembled[k*BW8 +: BW8] = slot_word[k];
  end

  assign slot0_oob = slot_oob[0];
  assign masked    = assembled & size_mask(rd_size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= masked;
    end
  end

endmodule

// File: rtl/qry_lane_fmt_chk.sv
module qry_lane_fmt_chk #(
  parameter int unsigned BANK_W    = 4,
  parameter int unsigned DEV_W     = 1,
  parameter int unsigned MAX_DEV_W = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic [1:0]  rd_size,
  input logic        id_mode,
  input logic        slot0_oob,
  input logic        rd_valid,
  input logic [31:0] rd_data
);

  initial begin
    p_width_cfg_r1: assert ((BANK_W == 1 || BANK_W == 2 || BANK_W == 4) &&
                            (DEV_W == 1 || DEV_W == 2 || DEV_W == 4) &&
                            (MAX_DEV_W == 1 || MAX_DEV_W == 2 || MAX_DEV_W == 4) &&
                            DEV_W <= MAX_DEV_W && DEV_W <= BANK_W)
      else $error("width parameters out of range");
  end

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && $stable(rd_data)));

  p_oob_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !id_mode && slot0_oob) |=> (rd_data[BANK_W*8-1:0] == '0));

  p_byte_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_size == 2'd0) |=> (rd_data[31:8] == 24'h0));

  p_half_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_size == 2'd1) |=> (rd_data[31:16] == 16'h0));

  generate
    if (BANK_W > DEV_W) begin : g_repl
      p_slot_repl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_size[1]) |=> (rd_data[DEV_W*8-1:0] == rd_data[DEV_W*8 +: DEV_W*8]));
    end
  endgenerate

endmodule

bind qry_lane_fmt qry_lane_fmt_chk #(
  .BANK_W(BANK_W), .DEV_W(DEV_W), .MAX_DEV_W(MAX_DEV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_size(rd_size),
  .id_mode(id_mode), .slot0_oob(slot0_oob), .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/test_qry_lane_fmt.sv
module test_qry_lane_fmt;

  localparam logic [15:0] MFR = 16'h1C89;
  localparam logic [15:0] DVC = 16'h4A17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [1:0]  rd_size = '0;
  logic        id_mode = 1'b0;
  logic        v_a, v_b, v_c;
  logic [31:0] d_a, d_b, d_c;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] ea, eb, ec;
    string       tag;
  } exp_t;
  exp_t sb[$];
  logic [31:0] last_a;

  always #5 clk = ~clk;

  // x8 parts able to run x16, 4-byte bank
  qry_lane_fmt i_qry_lane_fmt (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_size(rd_size),
    .id_mode(id_mode), .rd_valid(v_a), .rd_data(d_a));

  // native x16, 2-byte bank, short table
  qry_lane_fmt #(.BANK_W(2), .DEV_W(2), .MAX_DEV_W(2), .TBL_LEN('h12)) i_qry_lane_fmt_x16 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_size(rd_size),
    .id_mode(id_mode), .rd_valid(v_b), .rd_data(d_b));

  // x32-capable parts strapped x16 (table answers unsupported)
  qry_lane_fmt #(.BANK_W(4), .DEV_W(2), .MAX_DEV_W(4)) i_qry_lane_fmt_x16w (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_size(rd_size),
    .id_mode(id_mode), .rd_valid(v_c), .rd_data(d_c));

  function automatic logic [7:0] tb_tbl(int idx);
    logic [7:0] t;
    t = 8'h00;
    if (idx == 'h10) t = "Q";
    if (idx == 'h11) t = "R";
    if (idx == 'h12) t = "Y";
    if (idx == 'h13 || idx == 'h2C) t = 8'h01;
    if (idx == 'h15) t = 8'h31;
    if (idx == 'h1B) t = 8'h45;
    if (idx == 'h1C) t = 8'h55;
    if (idx == 'h31) t = "P";
    if (idx == 'h32) t = "R";
    if (idx == 'h33) t = "I";
    return t;
  endfunction

  // byte-by-byte model of the formatted word
  function automatic logic [31:0] model(int bw, int dw, int mw, int tlen,
                                        logic [15:0] a, logic [1:0] sz, logic idm);
    logic [31:0] r;
    logic [15:0] ak, code;
    logic [7:0]  v;
    int nb, k, d, idx;
    r = '0;
    nb = (sz == 0) ? 1 : ((sz == 1) ? 2 : 4);
    for (int b = 0; b < nb; b++) begin
      k   = b / bw;
      d   = (b % bw) % dw;
      ak  = a + 16'(k * bw);
      idx = int'(ak) / (bw * mw / dw);
      if (idm) begin
        code = ((idx % 256) == 0) ? MFR : (((idx % 256) == 1) ? DVC : 16'h0);
        v = (d < 2) ? code[d*8 +: 8] : 8'h00;
      end else if (idx >= tlen) v = 8'h00;
      else if (dw < mw && dw != 1) v = 8'h00;
      else if (dw < mw) v = tb_tbl(idx);
      else v = (d == 0) ? tb_tbl(idx) : 8'h00;
      r[b*8 +: 8] = v;
    end
    return r;
  endfunction

  task automatic issue(logic [15:0] a, logic [1:0] sz, logic idm, string tag);
    exp_t e;
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a; rd_size = sz; id_mode = idm;
    e.ea = model(4, 1, 2, 'h52, a, sz, idm);
    e.eb = model(2, 2, 2, 'h12, a, sz, idm);
    e.ec = model(4, 2, 4, 'h52, a, sz, idm);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic cmp(string tag, string inst, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, inst, act, exp);
    end
  endtask

  // monitor: pops expected items as results appear
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (v_a) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 unexpected valid actual=1 expected=0");
        end else begin
          e = sb.pop_front();
          cmp(e.tag, "a", d_a, e.ea);
          cmp(e.tag, "b", d_b, e.eb);
          cmp(e.tag, "c", d_c, e.ec);
          last_a = e.ea;
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R2 reset valid", "a", {31'd0, v_a}, 32'd0);
    cmp("R2 reset data", "a", d_a, 32'd0);
    rst_n = 1'b1;
    idle();
    // R3/R5: signature bytes, shift of 3 (a), 1 (b)
    issue(16'h0080, 2'd2, 1'b0, "R3/R5/R6 Q");
    issue(16'h0088, 2'd2, 1'b0, "R5/R6 R");
    issue(16'h0090, 2'd2, 1'b0, "R5/R6 Y");
    // R9: two bank slots on x16 bank, distinct answers
    issue(16'h0020, 2'd2, 1'b0, "R9 QR slots");
    // R4: table limit for short table (idx 0x11 in, 0x12 out)
    issue(16'h0022, 2'd2, 1'b0, "R4 limit");
    issue(16'h0024, 2'd2, 1'b0, "R4 beyond");
    issue(16'h0198, 2'd2, 1'b0, "R4/R5 last entries");
    issue(16'h0290, 2'd2, 1'b0, "R4 a limit");
    // R7/R8: identifier reads
    issue(16'h0000, 2'd2, 1'b1, "R7/R8 mfr");
    issue(16'h0008, 2'd2, 1'b1, "R7/R8 dev");
    issue(16'h0010, 2'd2, 1'b1, "R7 other");
    issue(16'h0800, 2'd2, 1'b1, "R7 low byte wrap");
    issue(16'h0002, 2'd2, 1'b1, "R9 id slots");
    // R10: sizes
    issue(16'h0080, 2'd0, 1'b0, "R10 size0");
    issue(16'h0080, 2'd1, 1'b0, "R10 size1");
    issue(16'h0080, 2'd3, 1'b0, "R10 size3");
    issue(16'h0000, 2'd1, 1'b1, "R10 id size1");
    // R9: address wrap
    issue(16'hFFFE, 2'd2, 1'b1, "R9 wrap");
    // R6: x8 repetition on other entries
    issue(16'h00D8, 2'd2, 1'b0, "R6 0x1B");
    idle();
    repeat (3) @(negedge clk);
    cmp("R2 idle valid", "a", {31'd0, v_a}, 32'd0);
    cmp("R2 hold data", "a", d_a, last_a);
    cmp("R2 queue drained", "a", 32'(sb.size()), 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule